// File: doc/BRIEF.md
# Accumulator ALU with Carry Rotate and Skip Test

This unit executes the register-to-register arithmetic and logic class of a four-accumulator processor in a single pass. Given one instruction word, it reads a source and a destination accumulator and applies one of eight functions. It then derives a carry bit from a selectable base value and passes the carry-plus-result word through a rotate or byte-swap stage. The outcome is tested against one of eight skip conditions, and the write-back can be suppressed.

The datapath is purely combinational. The accumulator file and the carry flag are registers. They take the shifted result on the rising clock edge when the execute strobe is high. A preset port loads an accumulator directly; a surrounding sequencer uses it to seed data. A read port lets the sequencer see any accumulator. The skip output tells the sequencer whether to step over the next instruction.

Top module: `alx_shift_skip_unit`

Instruction bit numbering follows the format: field "bit k" is `instr_i[15-k]`. So the class bit is `instr_i[15]`, source `[14:13]`, destination `[12:11]`, function `[10:8]`, shift `[7:6]`, carry base `[5:4]`, no-load `[3]`, skip `[2:0]`. In data words, "bit 0" is the most significant bit.

## Requirements
- R1: After reset, all four accumulators and the carry flag read zero.
- R2: Only a word with `instr_i[15]`=1 belongs to this class. Any other word writes nothing, leaves the carry unchanged and holds `skip_o` low.
- R3: Source S is the accumulator named by `instr_i[14:13]` and destination D by `instr_i[12:11]`. Function codes in `instr_i[10:8]` are: 0 gives ~S, 1 gives -S, 2 gives S, 3 gives S+1, 4 gives D+~S, 5 gives D-S, 6 gives D+S, 7 gives D&S.
- R4: Carry base `instr_i[5:4]` is 0 for the current carry, 1 for zero, 2 for the inverted current carry, and 3 for one. Logical functions (codes 0, 2, 7) pass the base unchanged.
- R5: Arithmetic functions (codes 1, 3, 4, 5, 6) pass the inverted base when a carry leaves the most significant bit, and the base otherwise. For code 5 that carry occurs exactly when unsigned D >= S.
- R6: Shift code 1 rotates the 17-bit {carry, result} word left: the result MSB goes to carry and the carry goes to the result LSB.
- R7: Shift code 2 rotates right: the result LSB goes to carry and the carry goes to the result MSB. Shift code 0 passes the word through.
- R8: Shift code 3 exchanges the upper and lower bytes of the result and leaves the carry bit as formed.
- R9: With `instr_i[3]`=1, neither the destination nor the carry is written, yet the skip test is still evaluated.
- R10: Skip code `instr_i[2:0]` is evaluated on the shifter output carry C and result R: 0 never, 1 always, 2 C==0, 3 C!=0, 4 R==0, 5 R!=0, 6 C==0 or R==0, 7 C!=0 and R!=0.
- R11: `wr_en_o` is high only while `exec_i` is high for a loading word of this class. On that clock edge the destination takes `wr_data_o` and the carry takes `carry_next_o`; without `exec_i` the state holds.
- R12: A preset loads `pre_data_i` into the accumulator `pre_idx_i` and does not touch the carry. If an execute writes the same accumulator in the same cycle, the execute result wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_i | input | 1 | Execute strobe; commits the current word on this edge |
| instr_i | input | 16 | Instruction word |
| pre_en_i | input | 1 | Preset enable |
| pre_idx_i | input | 2 | Accumulator to preset |
| pre_data_i | input | WIDTH | Preset value |
| rd_idx_i | input | 2 | Accumulator to observe |
| rd_data_o | output | WIDTH | Content of the observed accumulator |
| carry_o | output | 1 | Carry flag |
| wr_en_o | output | 1 | Destination and carry write enable |
| wr_idx_o | output | 2 | Destination accumulator |
| wr_data_o | output | WIDTH | Shifter result |
| carry_next_o | output | 1 | Shifter carry output |
| skip_o | output | 1 | Skip the next instruction |

## Verification
The bench builds the unit with its default WIDTH of 16, the width the instruction format was laid out for. At this width the bench can reach the full set of boundary values: an all-ones source that overflows on increment, the MSB-only word whose doubling carries out, and the zero source that makes negation carry. A sweep over every function with every shift and carry base covers the independent fields in combination. Directed words then cover equal and unequal subtraction, no-load skips, and a preset colliding with an execute on the same accumulator.

// File: rtl/alx_pkg.sv
package alx_pkg;

    localparam int INSTR_W = 16;
    localparam int NUM_ACC = 4;
    localparam int ACC_IW  = $clog2(NUM_ACC);

    typedef enum logic [2:0] {
        FN_COM = 3'd0,
        FN_NEG = 3'd1,
        FN_MOV = 3'd2,
        FN_INC = 3'd3,
        FN_ADC = 3'd4,
        FN_SUB = 3'd5,
        FN_ADD = 3'd6,
        FN_AND = 3'd7
    } alx_fn_e;

    typedef enum logic [1:0] {
        SH_NONE  = 2'd0,
        SH_ROTL  = 2'd1,
        SH_ROTR  = 2'd2,
        SH_SWAP  = 2'd3
    } alx_shift_e;

    typedef enum logic [1:0] {
        CB_KEEP = 2'd0,
        CB_ZERO = 2'd1,
        CB_INV  = 2'd2,
        CB_ONE  = 2'd3
    } alx_cbase_e;

    typedef enum logic [2:0] {
        SK_NEVER  = 3'd0,
        SK_ALWAYS = 3'd1,
        SK_CZ     = 3'd2,
        SK_CNZ    = 3'd3,
        SK_RZ     = 3'd4,
        SK_RNZ    = 3'd5,
        SK_EITHZ  = 3'd6,
        SK_BOTHNZ = 3'd7
    } alx_skip_e;

    typedef struct packed {
        logic                 op_class;
        logic [ACC_IW-1:0]    src;
        logic [ACC_IW-1:0]    dst;
        alx_fn_e              fn;
        alx_shift_e           sh;
        alx_cbase_e           cbase;
        logic                 no_load;
        alx_skip_e            skip;
    } alx_instr_t;

endpackage

// File: rtl/alx_func.sv
module alx_func
    import alx_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  alx_fn_e           fn_i,
    input  alx_cbase_e        cbase_i,
    input  logic              carry_i,
    input  logic [WIDTH-1:0]  s_i,
    input  logic [WIDTH-1:0]  d_i,
    output logic [WIDTH-1:0]  res_o,
    output logic              cout_o
);

    logic [WIDTH:0] sum;
    logic           arith;
    logic           base;

    always_comb begin
        unique case (cbase_i)
            CB_KEEP: base = carry_i;
            CB_ZERO: base = 1'b0;
            CB_INV:  base = ~carry_i;
            CB_ONE:  base = 1'b1;
        endcase
    end

    always_comb begin
        sum   = '0;
        arith = 1'b1;
        unique case (fn_i)
            FN_COM: begin sum = {1'b0, ~s_i};     arith = 1'b0; end
            FN_NEG:       sum = {1'b0, ~s_i} + 1'b1;
            FN_MOV: begin sum = {1'b0, s_i};      arith = 1'b0; end
            FN_INC:       sum = {1'b0, s_i} + 1'b1;
            FN_ADC:       sum = {1'b0, d_i} + {1'b0, ~s_i};
            FN_SUB:       sum = {1'b0, d_i} + {1'b0, ~s_i} + 1'b1;
            FN_ADD:       sum = {1'b0, d_i} + {1'b0, s_i};
            FN_AND: begin sum = {1'b0, d_i & s_i}; arith = 1'b0; end
        endcase
    end

    assign res_o  = sum[WIDTH-1:0];
    assign cout_o = arith ? (base ^ sum[WIDTH]) : base;

endmodule

// File: rtl/alx_shifter.sv
module alx_shifter
    import alx_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  alx_shift_e        sh_i,
    input  logic              c_i,
    input  logic [WIDTH-1:0]  r_i,
    output logic              c_o,
    output logic [WIDTH-1:0]  r_o
);

    localparam int HALF = WIDTH / 2;

    always_comb begin
        unique case (sh_i)
            SH_NONE: begin c_o = c_i;          r_o = r_i; end
            SH_ROTL: begin c_o = r_i[WIDTH-1]; r_o = {r_i[WIDTH-2:0], c_i}; end
            SH_ROTR: begin c_o = r_i[0];       r_o = {c_i, r_i[WIDTH-1:1]}; end
            SH_SWAP: begin c_o = c_i;          r_o = {r_i[HALF-1:0], r_i[WIDTH-1:HALF]}; end
        endcase
    end

endmodule

// File: rtl/alx_skip_eval.sv
module alx_skip_eval
    import alx_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  alx_skip_e         sk_i,
    input  logic              c_i,
    input  logic [WIDTH-1:0]  r_i,
    output logic              skip_o
);

    logic rz;
    assign rz = (r_i == '0);

    always_comb begin
        unique case (sk_i)
            SK_NEVER:  skip_o = 1'b0;
            SK_ALWAYS: skip_o = 1'b1;
            SK_CZ:     skip_o = ~c_i;
            SK_CNZ:    skip_o = c_i;
            SK_RZ:     skip_o = rz;
            SK_RNZ:    skip_o = ~rz;
            SK_EITHZ:  skip_o = ~c_i | rz;
            SK_BOTHNZ: skip_o = c_i & ~rz;
        endcase
    end

endmodule

// File: rtl/alx_accfile.sv
module alx_accfile
    import alx_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ACC_IW-1:0] widx_i,
    input  logic [WIDTH-1:0]  wdata_i,
    input  logic              pe_i,
    input  logic [ACC_IW-1:0] pidx_i,
    input  logic [WIDTH-1:0]  pdata_i,
    input  logic [ACC_IW-1:0] ra_idx_i,
    input  logic [ACC_IW-1:0] rb_idx_i,
    input  logic [ACC_IW-1:0] rc_idx_i,
    output logic [WIDTH-1:0]  ra_o,
    output logic [WIDTH-1:0]  rb_o,
    output logic [WIDTH-1:0]  rc_o
);

    logic [WIDTH-1:0] acc_q [NUM_ACC];

    for (genvar g = 0; g < NUM_ACC; g++) begin : g_acc
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                acc_q[g] <= '0;
            end else if (we_i && widx_i == ACC_IW'(g)) begin
                acc_q[g] <= wdata_i;
            end else if (pe_i && pidx_i == ACC_IW'(g)) begin
                acc_q[g] <= pdata_i;
            end
        end
    end

    assign ra_o = acc_q[ra_idx_i];
    assign rb_o = acc_q[rb_idx_i];
    assign rc_o = acc_q[rc_idx_i];

endmodule

// File: rtl/alx_shift_skip_unit.sv
module alx_shift_skip_unit
    import alx_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec_i,
    input  logic [15:0]       instr_i,
    input  logic              pre_en_i,
    input  logic [1:0]        pre_idx_i,
    input  logic [WIDTH-1:0]  pre_data_i,
    input  logic [1:0]        rd_idx_i,
    output logic [WIDTH-1:0]  rd_data_o,
    output logic              carry_o,
    output logic              wr_en_o,
    output logic [1:0]        wr_idx_o,
    output logic [WIDTH-1:0]  wr_data_o,
    output logic              carry_next_o,
    output logic              skip_o
);

    alx_instr_t        ins;
    logic [WIDTH-1:0]  s_val;
    logic [WIDTH-1:0]  d_val;
    logic [WIDTH-1:0]  fn_res;
    logic              fn_c;
    logic              sk_raw;
    logic              carry_q;

    assign ins = alx_instr_t'(instr_i);

    alx_accfile #(.WIDTH(WIDTH)) acc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (wr_en_o),
        .widx_i   (wr_idx_o),
        .wdata_i  (wr_data_o),
        .pe_i     (pre_en_i),
        .pidx_i   (pre_idx_i),
        .pdata_i  (pre_data_i),
        .ra_idx_i (ins.src),
        .rb_idx_i (ins.dst),
        .rc_idx_i (rd_idx_i),
        .ra_o     (s_val),
        .rb_o     (d_val),
        .rc_o     (rd_data_o)
    );

    alx_func #(.WIDTH(WIDTH)) func_i (
        .fn_i    (ins.fn),
        .cbase_i (ins.cbase),
        .carry_i (carry_q),
        .s_i     (s_val),
        .d_i     (d_val),
        .res_o   (fn_res),
        .cout_o  (fn_c)
    );

    alx_shifter #(.WIDTH(WIDTH)) shift_i (
        .sh_i (ins.sh),
        .c_i  (fn_c),
        .r_i  (fn_res),
        .c_o  (carry_next_o),
        .r_o  (wr_data_o)
    );

    alx_skip_eval #(.WIDTH(WIDTH)) skip_i (
        .sk_i   (ins.skip),
        .c_i    (carry_next_o),
        .r_i    (wr_data_o),
        .skip_o (sk_raw)
    );

    assign wr_en_o  = exec_i & ins.op_class & ~ins.no_load;
    assign wr_idx_o = ins.dst;
    assign skip_o   = ins.op_class & sk_raw;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            carry_q <= 1'b0;
        end else if (wr_en_o) begin
            carry_q <= carry_next_o;
        end
    end

    assign carry_o = carry_q;

endmodule

// File: rtl/alx_shift_skip_chk.sv
module alx_shift_skip_chk #(
    parameter int WIDTH = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              exec_i,
    input logic [15:0]       instr_i,
    input logic              carry_o,
    input logic              wr_en_o,
    input logic [WIDTH-1:0]  wr_data_o,
    input logic              carry_next_o,
    input logic              skip_o
);

    // R2
    nonclass_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_i[15] |-> (!wr_en_o && !skip_o));

    // R9
    noload_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        instr_i[3] |-> !wr_en_o);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_i |=> $stable(carry_o));

    // R11
    carry_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> (carry_o == $past(carry_next_o)));

    // R10
    skip_never_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_i[2:0] == 3'd0) |-> !skip_o);

    // R10
    skip_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_i[15] && instr_i[2:0] == 3'd4) |-> (skip_o == (wr_data_o == '0)));

    // R8
    swap_keeps_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_i[15] && instr_i[10:8] == 3'd2 && instr_i[7:6] == 2'b11
         && instr_i[5:4] == 2'b11) |-> carry_next_o);

    // R4
    logic_zero_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_i[15] && instr_i[10:8] == 3'd7 && instr_i[7:6] == 2'b00
         && instr_i[5:4] == 2'b01) |-> !carry_next_o);

endmodule

bind alx_shift_skip_unit alx_shift_skip_chk #(.WIDTH(WIDTH)) chk_i (.*);

// File: tb/alx_shift_skip_unit_tb_top.sv
module alx_shift_skip_unit_tb_top;

    localparam int W = 16;

    typedef struct {
        logic          cls;
        logic          wen;
        logic [1:0]    widx;
        logic [W-1:0]  data;
        logic          cnext;
        logic          skip;
        string         req;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          exec_i = 1'b0;
    logic [15:0]   instr_i = '0;
    logic          pre_en_i = 1'b0;
    logic [1:0]    pre_idx_i = '0;
    logic [W-1:0]  pre_data_i = '0;
    logic [1:0]    rd_idx_i = '0;
    logic [W-1:0]  rd_data_o;
    logic          carry_o;
    logic          wr_en_o;
    logic [1:0]    wr_idx_o;
    logic [W-1:0]  wr_data_o;
    logic          carry_next_o;
    logic          skip_o;

    int            n_checks = 0;
    int            n_fails = 0;
    exp_t          sb_q[$];
    event          smp_ev;
    logic [W-1:0]  m_acc [4];
    logic          m_c;

    always #5 clk = ~clk;

    alx_shift_skip_unit #(.WIDTH(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .instr_i(instr_i),
        .pre_en_i(pre_en_i), .pre_idx_i(pre_idx_i), .pre_data_i(pre_data_i),
        .rd_idx_i(rd_idx_i), .rd_data_o(rd_data_o), .carry_o(carry_o),
        .wr_en_o(wr_en_o), .wr_idx_o(wr_idx_o), .wr_data_o(wr_data_o),
        .carry_next_o(carry_next_o), .skip_o(skip_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input int src, input int dst, input int fn,
                                       input int sh, input int cb, input int nl,
                                       input int sk);
        return {1'b1, 2'(src), 2'(dst), 3'(fn), 2'(sh), 2'(cb), 1'(nl), 3'(sk)};
    endfunction

    // Reference from the requirement text: returns {skip, carry, result}
    function automatic logic [W+1:0] model(input logic [15:0] ins);
        logic [W-1:0] s, d, r;
        logic [W:0]   t;
        logic         base, c, co, ar, sk;
        s = m_acc[ins[14:13]];
        d = m_acc[ins[12:11]];
        case (ins[5:4])
            2'd0: base = m_c;
            2'd1: base = 1'b0;
            2'd2: base = ~m_c;
            default: base = 1'b1;
        endcase
        ar = 1'b1;
        case (ins[10:8])
            3'd0: begin t = {1'b0, ~s}; ar = 1'b0; end
            3'd1: t = 17'h10000 - {1'b0, s};
            3'd2: begin t = {1'b0, s}; ar = 1'b0; end
            3'd3: t = {1'b0, s} + 17'd1;
            3'd4: t = {1'b0, d} + {1'b0, ~s};
            3'd5: t = {(d >= s), d - s};
            3'd6: t = {1'b0, d} + {1'b0, s};
            default: begin t = {1'b0, d & s}; ar = 1'b0; end
        endcase
        if (ins[10:8] == 3'd1) t[W] = (s == '0);
        co = t[W];
        r  = t[W-1:0];
        c  = ar ? (co ? ~base : base) : base;
        case (ins[7:6])
            2'd1: begin {c, r} = {r, c}; end
            2'd2: begin {r, c} = {c, r}; end
            2'd3: r = {r[7:0], r[15:8]};
            default: ;
        endcase
        case (ins[2:0])
            3'd0: sk = 1'b0;
            3'd1: sk = 1'b1;
            3'd2: sk = !c;
            3'd3: sk = c;
            3'd4: sk = (r == 0);
            3'd5: sk = (r != 0);
            3'd6: sk = !c || (r == 0);
            default: sk = c && (r != 0);
        endcase
        return {sk, c, r};
    endfunction

    // Monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            @(smp_ev);
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                chk(wr_en_o == e.wen, e.req, "wr_en", 32'(wr_en_o), 32'(e.wen));
                chk(skip_o == e.skip, e.req, "skip", 32'(skip_o), 32'(e.skip));
                if (e.cls) begin
                    chk(wr_data_o == e.data, e.req, "result", 32'(wr_data_o), 32'(e.data));
                    chk(carry_next_o == e.cnext, e.req, "carry_next",
                        32'(carry_next_o), 32'(e.cnext));
                    chk(wr_idx_o == e.widx, e.req, "wr_idx", 32'(wr_idx_o), 32'(e.widx));
                end
            end
        end
    end

    task automatic check_state(input string req);
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            rd_idx_i = 2'(i);
            #1;
            chk(rd_data_o == m_acc[i], req, $sformatf("acc%0d", i),
                32'(rd_data_o), 32'(m_acc[i]));
        end
        chk(carry_o == m_c, req, "carry", 32'(carry_o), 32'(m_c));
    endtask

    task automatic preset(input int idx, input logic [W-1:0] val);
        @(negedge clk);
        pre_en_i = 1'b1; pre_idx_i = 2'(idx); pre_data_i = val;
        @(posedge clk); #1;
        pre_en_i = 1'b0;
        m_acc[idx] = val;
    endtask

    // Driver: applies a word, pushes its expected item, then commits
    task automatic run(input logic [15:0] ins, input string req, input bit with_pre,
                       input int pidx, input logic [W-1:0] pval);
        exp_t e;
        logic [W+1:0] m;
        @(negedge clk);
        exec_i = 1'b1; instr_i = ins;
        if (with_pre) begin
            pre_en_i = 1'b1; pre_idx_i = 2'(pidx); pre_data_i = pval;
        end
        m = model(ins);
        e.cls = ins[15]; e.wen = ins[15] && !ins[3]; e.widx = ins[12:11];
        e.data = m[W-1:0]; e.cnext = m[W]; e.skip = ins[15] && m[W+1]; e.req = req;
        #2;
        sb_q.push_back(e);
        ->smp_ev;
        @(posedge clk); #1;
        exec_i = 1'b0; pre_en_i = 1'b0;
        if (with_pre) m_acc[pidx] = pval;
        if (e.wen) begin
            m_acc[ins[12:11]] = m[W-1:0];
            m_c = m[W];
        end
    endtask

    initial begin
        #(200000 * 10);
        n_checks++; n_fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) m_acc[i] = '0;
        m_c = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        check_state("R1");

        preset(0, 16'h1234); preset(1, 16'h00FF);
        preset(2, 16'h8000); preset(3, 16'hFFFF);
        check_state("R12");

        // R3 R4 R6 R7 R8 R10: sweep every function with every shift
        for (int fn = 0; fn < 8; fn++) begin
            preset(fn % 4, 16'hA5C3 ^ 16'(fn * 16'h1357));
            for (int sh = 0; sh < 4; sh++) begin
                run(mk((fn + sh) % 4, (fn * 3 + sh + 1) % 4, fn, sh, (fn + sh) % 4,
                       0, (fn * 2 + sh) % 8), "R3", 0, 0, '0);
                check_state("R3");
            end
        end

        // R5: increment of all ones, negate of zero, subtract equal and less
        preset(0, 16'hFFFF); preset(1, 16'h0000);
        run(mk(0, 2, 3, 0, 1, 0, 3), "R5", 0, 0, '0);
        check_state("R5");
        run(mk(1, 2, 1, 0, 1, 0, 4), "R5", 0, 0, '0);
        check_state("R5");
        preset(0, 16'd5); preset(1, 16'd5);
        run(mk(0, 1, 5, 0, 1, 0, 6), "R5", 0, 0, '0);
        check_state("R5");
        preset(1, 16'd4);
        run(mk(0, 1, 5, 0, 1, 0, 2), "R5", 0, 0, '0);
        check_state("R5");
        preset(2, 16'h8000); preset(3, 16'h8000);
        run(mk(2, 3, 6, 0, 2, 0, 7), "R5", 0, 0, '0);
        check_state("R5");

        // R6 R7: rotate with carry set
        preset(0, 16'h8001);
        run(mk(0, 1, 2, 0, 3, 0, 0), "R4", 0, 0, '0);
        run(mk(0, 1, 2, 1, 0, 0, 3), "R6", 0, 0, '0);
        check_state("R6");
        run(mk(0, 2, 2, 2, 3, 0, 2), "R7", 0, 0, '0);
        check_state("R7");
        run(mk(0, 3, 2, 3, 3, 0, 5), "R8", 0, 0, '0);
        check_state("R8");

        // R9: no-load still skips
        run(mk(3, 0, 0, 0, 3, 1, 1), "R9", 0, 0, '0);
        check_state("R9");
        run(mk(1, 1, 6, 1, 2, 1, 7), "R9", 0, 0, '0);
        check_state("R9");

        // R2: words outside the class
        run(16'h7FFF, "R2", 0, 0, '0);
        check_state("R2");
        run(16'h0001, "R2", 0, 0, '0);
        check_state("R2");

        // R11: no strobe, no change
        @(negedge clk);
        instr_i = mk(0, 1, 0, 0, 3, 0, 0);
        repeat (2) @(posedge clk);
        check_state("R11");

        // R12: preset and execute on the same accumulator, execute wins
        run(mk(2, 1, 3, 0, 0, 0, 0), "R12", 1, 1, 16'hBEEF);
        check_state("R12");
        // R12: preset on another accumulator in the same cycle also lands
        run(mk(2, 1, 2, 0, 0, 0, 0), "R12", 1, 3, 16'h0F0F);
        check_state("R12");

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

endmodule